// File: doc/BRIEF.md
# Parallel Converter Bus Sequencer

This block is the digital control logic for an 8-bit converter that sits on a parallel microprocessor bus. It samples asynchronous bus strobes (chip select, read, write) and a mode pin on a synchronous system clock. It sequences conversions and latches the code and over-range flag supplied by the comparator stage into an output register. It also produces the interrupt, ready, overflow and data-enable signals that the bus side needs.

Two bus modes exist. In write-read mode a write strobe starts a conversion. An internal countdown then finishes it, unless a read arrives first and cuts the wait short. In read-only mode a read strobe starts the conversion and a ready line holds the processor until the result is latched. The ready line is presented as a drive-low enable with a complementary release flag. The data bus is a plain value plus an output enable, with no tri-state inside the block. Data moves as single latched words under bus strobes, so there is no valid/ready stream and no back-pressure. The comparator inputs are sampled only on the latch cycle.

Top module: `adc_bus_seq`

## Requirements
- R1: Falling read or write strobes are ignored while the synchronised chip select is high: no conversion starts, interrupt stays high and the data enable stays low.
- R2: Synchronised mode high selects write-read mode and low selects read mode. The mode is sampled when a conversion starts. A write strobe in read mode starts nothing. After reset the mode is taken as low.
- R3: In write-read mode a write fall with chip select low starts a conversion. The result latches DELAY_CYC clock cycles after the synchronised write rise, and int_n goes low at that edge. Measured from the wr_n pin rising, that is DELAY_CYC+3 rising edges.
- R4: In write-read mode, a read fall with chip select low before the countdown ends latches the result at once. int_n is low 3 rising edges after the rd_n pin falls.
- R5: int_n returns high on a synchronised rising edge of read or of chip select. The rise of read counts even with chip select high. If a latch falls on the same edge, the latch wins and int_n goes low.
- R6: In write-read mode dout_oe is high exactly when chip select and read are both low, one cycle after their synchronised levels.
- R7: In read mode a read fall with chip select low starts a conversion that latches DELAY_CYC cycles later (DELAY_CYC+3 rising edges from the rd_n pin). dout_oe stays low until the latch and is then high while chip select and read are low.
- R8: In read mode a synchronised chip select fall sets rdy_low=1 and rdy_hiz=0. A latch, or a chip select rise, sets rdy_low=0 and rdy_hiz=1. The two outputs are always complementary.
- R9: At each latch, dout takes code_in and ovf_n takes the inverse of over_in (low means over-range), both sampled on the latch edge. Between latches both hold.
- R10: After reset int_n=1, ovf_n=1, dout=0, dout_oe=0, rdy_low=0, rdy_hiz=1. Each pin is seen by the control logic on the third rising edge after it changes (two synchroniser flops plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| mode_wr | input | 1 | Mode pin: 1 write-read, 0 read-only |
| code_in | input | DATA_W | Conversion code from comparator stage |
| over_in | input | 1 | Over-range flag from comparator stage |
| int_n | output | 1 | Conversion-complete interrupt, active low |
| rdy_low | output | 1 | Drive-low enable for the ready line |
| rdy_hiz | output | 1 | Ready line released |
| ovf_n | output | 1 | Overflow flag, low when over-range |
| dout | output | DATA_W | Latched conversion result |
| dout_oe | output | 1 | Data bus output enable |

## Verification
The countdown expiry and the clearing of the interrupt can fall on the same clock edge. The bench provokes this by releasing chip select exactly DELAY_CYC cycles after releasing write, so the synchronised chip select rise meets the expiry. It judges that int_n goes low and stays low, and that dout carries the new code. An early read falling on the same edge as the write rise is also reached in the pseudo-random phase, where the cycle model decides the outcome every clock.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WR_LOW   = 2'd1,
    ST_WR_COUNT = 2'd2,
    ST_RD_CONV  = 2'd3
  } seq_state_t;

  // bit positions of the synchronised pin vector
  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_RD   = 1;
  localparam int unsigned PIN_WR   = 2;
  localparam int unsigned PIN_MODE = 3;
  localparam int unsigned PIN_NUM  = 4;
  localparam int unsigned EDGE_NUM = 3;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic q1, q2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q1 <= RST_VAL[i];
        q2 <= RST_VAL[i];
      end else begin
        q1 <= din[i];
        q2 <= q1;
      end
    end
    assign lvl[i] = q2;
  end
endmodule

// File: rtl/edge_det.sv
module edge_det #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/delay_timer.sv
module delay_timer #(
  parameter int unsigned DELAY_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic expired
);
  localparam int unsigned CNT_W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DELAY_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= LOAD_VAL;
    end else if (cancel || (run && cnt == '0)) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);
endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DELAY_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              mode_wr,
  input  logic [DATA_W-1:0] code_in,
  input  logic              over_in,
  output logic              int_n,
  output logic              rdy_low,
  output logic              rdy_hiz,
  output logic              ovf_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  logic [PIN_NUM-1:0]  pin_lvl;
  logic [EDGE_NUM-1:0] pin_rise, pin_fall;

  pin_sync #(.WIDTH(PIN_NUM), .RST_VAL(4'b0111)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({mode_wr, wr_n, rd_n, cs_n}),
    .lvl(pin_lvl)
  );

  edge_det #(.WIDTH(EDGE_NUM), .RST_VAL(3'b111)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl(pin_lvl[EDGE_NUM-1:0]),
    .rise(pin_rise), .fall(pin_fall)
  );

  logic cs_lvl, rd_lvl, mode_lvl;
  logic cs_rise, cs_fall, rd_rise, rd_fall, wr_rise, wr_fall;
  assign cs_lvl   = pin_lvl[PIN_CS];
  assign rd_lvl   = pin_lvl[PIN_RD];
  assign mode_lvl = pin_lvl[PIN_MODE];
  assign cs_rise  = pin_rise[PIN_CS];
  assign cs_fall  = pin_fall[PIN_CS];
  assign rd_rise  = pin_rise[PIN_RD];
  assign rd_fall  = pin_fall[PIN_RD];
  assign wr_rise  = pin_rise[PIN_WR];
  assign wr_fall  = pin_fall[PIN_WR];

  seq_state_t st, st_d;
  logic expired, latch, start_wr, start_rd, tmr_start, rd_sel_fall;
  logic vld_q, vld_d;

  delay_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(tmr_start), .cancel(latch),
    .expired(expired)
  );

  always_comb begin
    rd_sel_fall = rd_fall && !cs_lvl;
    start_wr    = (st == ST_IDLE) && !cs_lvl && mode_lvl && wr_fall;
    start_rd    = (st == ST_IDLE) && !cs_lvl && !mode_lvl && rd_fall;
    unique case (st)
      ST_WR_LOW:   latch = rd_sel_fall;
      ST_WR_COUNT: latch = rd_sel_fall || expired;
      ST_RD_CONV:  latch = expired;
      default:     latch = 1'b0;
    endcase
    tmr_start = start_rd || ((st == ST_WR_LOW) && wr_rise && !latch);

    st_d = st;
    if (latch)                              st_d = ST_IDLE;
    else if (start_wr)                      st_d = ST_WR_LOW;
    else if (start_rd)                      st_d = ST_RD_CONV;
    else if ((st == ST_WR_LOW) && wr_rise)  st_d = ST_WR_COUNT;

    vld_d = vld_q;
    if (latch)                  vld_d = 1'b1;
    else if (start_wr || start_rd) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      vld_q   <= 1'b0;
      int_n   <= 1'b1;
      ovf_n   <= 1'b1;
      dout    <= '0;
      dout_oe <= 1'b0;
      rdy_low <= 1'b0;
    end else begin
      st      <= st_d;
      vld_q   <= vld_d;
      dout_oe <= !cs_lvl && !rd_lvl && (mode_lvl || vld_d);

      if (latch)                  int_n <= 1'b0;
      else if (rd_rise || cs_rise) int_n <= 1'b1;

      if (latch) begin
        dout  <= code_in;
        ovf_n <= !over_in;
      end

      if (latch || cs_rise)          rdy_low <= 1'b0;
      else if (cs_fall && !mode_lvl) rdy_low <= 1'b1;
    end
  end

  assign rdy_hiz = !rdy_low;
endmodule

// File: rtl/adc_bus_seq_chk.sv
module adc_bus_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input seq_state_t        st,
  input logic              cs_lvl,
  input logic              rd_lvl,
  input logic              mode_lvl,
  input logic              cs_rise,
  input logic              cs_fall,
  input logic              rd_rise,
  input logic [DATA_W-1:0] code_in,
  input logic              over_in,
  input logic              int_n,
  input logic [DATA_W-1:0] dout,
  input logic              ovf_n,
  input logic              dout_oe,
  input logic              rdy_low
);
  logic busy;
  assign busy = (st != ST_IDLE);

  // R1: a conversion only begins from a selected chip
  a_r1_start_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cs_lvl));

  // R9: latched word and flag reflect the comparator on the latch edge
  a_r9_latch_data: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> (dout == $past(code_in)) && (ovf_n == !$past(over_in)));

  // R5: interrupt only clears after a read or select rise
  a_r5_int_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> $past(rd_rise || cs_rise));

  // R6: the bus is only driven while selected and reading
  a_r6_oe_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> $past(!cs_lvl && !rd_lvl));

  // R8: ready is only pulled low by a select fall in read mode
  a_r8_rdy_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_low) |-> $past(cs_fall && !mode_lvl));
endmodule

bind adc_bus_seq adc_bus_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st),
  .cs_lvl(cs_lvl), .rd_lvl(rd_lvl), .mode_lvl(mode_lvl),
  .cs_rise(cs_rise), .cs_fall(cs_fall), .rd_rise(rd_rise),
  .code_in(code_in), .over_in(over_in),
  .int_n(int_n), .dout(dout), .ovf_n(ovf_n),
  .dout_oe(dout_oe), .rdy_low(rdy_low)
);

// File: tb/adc_bus_seq_test.sv
`timescale 1ns/1ps
module adc_bus_seq_test;
  localparam int D = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mode_wr = 1'b0, over_in = 1'b0;
  logic [7:0] code_in = 8'h00;
  logic int_n, rdy_low, rdy_hiz, ovf_n, dout_oe;
  logic [7:0] dout;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0, model_on = 1'b0;

  always #2 clk = ~clk;

  adc_bus_seq #(.DATA_W(8), .DELAY_CYC(D)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .mode_wr(mode_wr), .code_in(code_in), .over_in(over_in),
    .int_n(int_n), .rdy_low(rdy_low), .rdy_hiz(rdy_hiz), .ovf_n(ovf_n),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int p1[4], p2[4], pv[3];   // index 0 cs, 1 rd, 2 wr, 3 mode
  int m_st, m_cnt, m_vld;
  bit m_run;
  int e_int, e_ovf, e_dout, e_oe, e_rdy;

  always @(posedge clk) begin
    if (!rst_n) begin
      p1 = '{1, 1, 1, 0}; p2 = '{1, 1, 1, 0}; pv = '{1, 1, 1};
      m_st = 0; m_cnt = 0; m_vld = 0; m_run = 0;
      e_int = 1; e_ovf = 1; e_dout = 0; e_oe = 0; e_rdy = 0;
    end else begin
      bit sel, md, csr, csf, rdr, rdf, wrr, wrf, expd, lat, s_wr, s_rd, tst;
      sel = (p2[0] == 0); md = (p2[3] == 1);
      csr = p2[0] && !pv[0]; csf = !p2[0] && pv[0];
      rdr = p2[1] && !pv[1]; rdf = !p2[1] && pv[1];
      wrr = p2[2] && !pv[2]; wrf = !p2[2] && pv[2];
      expd = m_run && (m_cnt == 0);
      lat = (m_st == 1 && sel && rdf) || (m_st == 2 && ((sel && rdf) || expd)) ||
            (m_st == 3 && expd);
      s_wr = (m_st == 0) && sel && md && wrf;
      s_rd = (m_st == 0) && sel && !md && rdf;
      tst = s_rd || (m_st == 1 && wrr && !lat);
      if (tst) begin m_run = 1; m_cnt = D - 1; end
      else if (lat || expd) m_run = 0;
      else if (m_run) m_cnt--;
      if (lat) m_st = 0;
      else if (s_wr) m_st = 1;
      else if (s_rd) m_st = 3;
      else if (m_st == 1 && wrr) m_st = 2;
      if (lat) m_vld = 1; else if (s_wr || s_rd) m_vld = 0;
      e_oe = (sel && p2[1] == 0 && (md || m_vld != 0)) ? 1 : 0;
      if (lat) e_int = 0; else if (rdr || csr) e_int = 1;
      if (lat) begin e_dout = code_in; e_ovf = !over_in; end
      if (lat || csr) e_rdy = 0; else if (csf && !md) e_rdy = 1;
      for (int i = 0; i < 3; i++) pv[i] = p2[i];
      for (int i = 0; i < 4; i++) p2[i] = p1[i];
      p1 = '{int'(cs_n), int'(rd_n), int'(wr_n), int'(mode_wr)};
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n && !done) begin
      chk("R3/R4/R5 int_n", int_n, e_int);
      chk("R9 dout", dout, e_dout);
      chk("R9 ovf_n", ovf_n, e_ovf);
      chk("R6/R7 dout_oe", dout_oe, e_oe);
      chk("R8 rdy_low", rdy_low, e_rdy);
      chk("R8 rdy_hiz", rdy_hiz, !e_rdy);
    end
  end

  // ---------------- directed helpers ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cycles_to_int_low(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (int_n != 1'b0 && n < 300);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int n;
    tick(3);
    // R10 reset state
    chk("R10 int_n", int_n, 1); chk("R10 ovf_n", ovf_n, 1);
    chk("R10 dout", dout, 0);   chk("R10 dout_oe", dout_oe, 0);
    chk("R10 rdy_low", rdy_low, 0); chk("R10 rdy_hiz", rdy_hiz, 1);
    rst_n = 1'b1; model_on = 1'b1;
    tick(2);

    // R1: strobes with chip select high do nothing
    mode_wr = 1'b1; code_in = 8'h11; tick(4);
    wr_n = 1'b0; tick(3); wr_n = 1'b1; tick(D + 10);
    chk("R1 int_n stays high", int_n, 1);
    rd_n = 1'b0; tick(5);
    chk("R1 dout_oe low", dout_oe, 0);
    rd_n = 1'b1; mode_wr = 1'b0; tick(4);
    rd_n = 1'b0; tick(3); rd_n = 1'b1; tick(D + 10);
    chk("R1 read mode int_n high", int_n, 1);
    chk("R1 rdy_low low", rdy_low, 0);

    // R2: write strobe in read mode starts nothing
    cs_n = 1'b0; tick(4);
    wr_n = 1'b0; tick(3); wr_n = 1'b1; tick(D + 10);
    chk("R2 no write-start in read mode", int_n, 1);
    cs_n = 1'b1; tick(5);

    // R3: full countdown in write-read mode
    mode_wr = 1'b1; code_in = 8'hA5; over_in = 1'b0; tick(4);
    cs_n = 1'b0; tick(4);
    wr_n = 1'b0; tick(4);
    wr_n = 1'b1;
    cycles_to_int_low(n);
    chk("R3 edges from wr rise to int low", n, D + 3);
    chk("R9 dout after countdown", dout, 8'hA5);
    chk("R9 ovf_n not over", ovf_n, 1);
    // R6 enable with select and read
    rd_n = 1'b0; tick(3);
    chk("R6 oe high while selected+read", dout_oe, 1);
    rd_n = 1'b1; tick(3);
    chk("R5 int high after rd rise", int_n, 1);
    chk("R6 oe low after rd rise", dout_oe, 0);
    cs_n = 1'b1; tick(5);

    // R4: early read cuts the countdown
    cs_n = 1'b0; tick(4);
    wr_n = 1'b0; tick(3); wr_n = 1'b1; tick(8);
    code_in = 8'h3C; over_in = 1'b1;
    rd_n = 1'b0;
    cycles_to_int_low(n);
    chk("R4 edges from rd fall to int low", n, 3);
    chk("R9 dout early read", dout, 8'h3C);
    chk("R9 ovf_n over-range", ovf_n, 0);
    rd_n = 1'b1; tick(4); cs_n = 1'b1; tick(5);
    over_in = 1'b0;

    // R5: expiry and chip select rise on the same edge
    cs_n = 1'b0; code_in = 8'h5A; tick(4);
    wr_n = 1'b0; tick(3); wr_n = 1'b1;
    tick(D); cs_n = 1'b1; tick(6);
    chk("R5 latch wins over cs rise", int_n, 0);
    chk("R9 dout coincident latch", dout, 8'h5A);
    rd_n = 1'b0; tick(3); rd_n = 1'b1; tick(4);
    chk("R5 rd rise clears int unselected", int_n, 1);

    // R7/R8: read mode
    mode_wr = 1'b0; code_in = 8'hC3; tick(4);
    cs_n = 1'b0; tick(3);
    chk("R8 rdy_low after cs fall", rdy_low, 1);
    chk("R8 rdy_hiz after cs fall", rdy_hiz, 0);
    rd_n = 1'b0; tick(10);
    chk("R7 oe low while converting", dout_oe, 0);
    chk("R8 rdy held low while converting", rdy_low, 1);
    tick(D - 7);
    chk("R7 int low at completion", int_n, 0);
    chk("R7 oe high after completion", dout_oe, 1);
    chk("R8 rdy released at latch", rdy_hiz, 1);
    chk("R9 dout read mode", dout, 8'hC3);
    rd_n = 1'b1; tick(4); cs_n = 1'b1; tick(6);

    // pseudo-random phase against the cycle model
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 29) == 0) cs_n = ~cs_n;
      if ($urandom_range(0, 9) == 0)  rd_n = ~rd_n;
      if ($urandom_range(0, 9) == 0)  wr_n = ~wr_n;
      if ($urandom_range(0, 199) == 0) mode_wr = ~mode_wr;
      if ($urandom_range(0, 3) == 0) begin
        code_in = 8'($urandom());
        over_in = 1'($urandom());
      end
    end
    tick(5);
    finish_run();
  end
endmodule